// File: doc/BRIEF.md
# Synchronous Serial Port Register Front End

This block is the bus-facing register file for a synchronous serial port master. A host issues word-aligned reads and writes on a 12-bit byte address. Writing the data register queues a word for transmission, and reading it takes the oldest received word. Further registers hold frame size, port control, prescale, interrupt mask and status. A read-only identification window sits at the top of the 4 KiB space.

Between the two 8-entry queues sits a minimal transfer engine. While the port is enabled, it moves one word per clock from the transmit queue to the receive queue, provided the transmit queue holds data and the receive queue has room. In loopback mode the received word is the transmitted word itself. Otherwise the word is presented on an external link, and the word on the link input is captured and masked to the frame size. Clock generation and frame formats are not modelled, and neither are slave operation or DMA.

Top module: `serport_regs`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0x03, the raw interrupt register (0x18) reads 0x2, the masked interrupt register (0x1C) reads 0, and `irq` is low. Status bits are: bit0 transmit empty, bit1 transmit not full, bit2 receive not empty, bit3 receive full, bit4 busy (enabled with transmit data pending).
- R2: The low 4 bits N of control 0 (offset 0x00) set the frame size. A word written to the data register (0x08) is stored ANDed with a mask whose low N+1 bits are ones.
- R3: Words leave the receive queue in the order they were written to the data register, and at most one word moves per clock.
- R4: A data-register write that finds 8 words in the transmit queue is discarded and changes no state.
- R5: A data-register read with an empty receive queue returns 0 and changes no state.
- R6: The prescale register (0x10) keeps only the low 8 bits of the written value.
- R7: The masked interrupt register reads mask (0x14, 2 bits) AND raw status, and `irq` is high exactly when that value is non-zero, one clock after a mask write.
- R8: Word reads at offsets 0xFE0 + 4k (k = 0..7) return the identification byte 0x50 + 0x11·k.
- R9: The DMA control register (0x20) and undefined offsets read 0, and writes to them alter no register.
- R10: Control 1 (0x04) stores 4 bits: bit0 loopback, bit1 port enable, bits 3:2 stored only. Control 0 stores 16 bits. Words move only while bit1 is set.
- R11: Raw interrupt bit0 is set while the receive queue holds 4 or more words. Bit1 is set while the transmit queue holds 4 or fewer.
- R12: With loopback clear, each move presents the transmit word on `link_tx_word` with a one-cycle `link_strobe`, and the receive queue gets `link_rx_word` masked to the frame size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| irq | output | 1 | Combined interrupt |
| link_tx_word | output | 16 | Word sent on the external link |
| link_strobe | output | 1 | External transfer happens this cycle |
| link_rx_word | input | 16 | Word received from the external link |

## Verification
Words are pushed at several frame sizes (4, 8 and 16 bits), so mask errors show up as corrupted bits in the received stream. The transmit queue is filled while the port is disabled. This separates "engine idle" from "engine moving" and lets the interrupt thresholds be hit at exactly 4 and 5 entries. A saturation pattern fills both queues and offers a ninth word. This shows that overflow words are dropped, that order survives the refill that happens while reading, and that the busy flag holds while the engine is stalled. A final external-link run tells loopback data apart from link data.

// File: rtl/serport_pkg.sv
// Shared constants and types for the serial port register front end.
// Assumes a 12-bit byte address and word-aligned accesses.
package serport_pkg;
    localparam logic [11:0] OFS_CTL0   = 12'h000;
    localparam logic [11:0] OFS_CTL1   = 12'h004;
    localparam logic [11:0] OFS_DATA   = 12'h008;
    localparam logic [11:0] OFS_STAT   = 12'h00C;
    localparam logic [11:0] OFS_PRESC  = 12'h010;
    localparam logic [11:0] OFS_IMASK  = 12'h014;
    localparam logic [11:0] OFS_RAW    = 12'h018;
    localparam logic [11:0] OFS_MIS    = 12'h01C;
    localparam logic [11:0] OFS_DMA    = 12'h020;
    localparam logic [6:0]  ID_PAGE    = 7'h7F;   // addr[11:5] of 0xFE0..0xFFC
    localparam logic [7:0]  ID_BASE    = 8'h50;
    localparam logic [7:0]  ID_STEP    = 8'h11;
    localparam int          C1_LOOP    = 0;
    localparam int          C1_ENABLE  = 1;

    // Status word, bit0 first: tx_empty, tx_nfull, rx_nempty, rx_full, busy
    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;
endpackage

// File: rtl/serport_fifo.sv
// Circular queue with a write head and an occupancy count. The oldest
// entry sits at (head - count) mod DEPTH. Assumes DEPTH is a power of two
// and that the caller never pushes when full or pops when empty.
module serport_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] head;
    logic [AW-1:0] rd_idx;

    // oldest entry index
    assign rd_idx   = head - count[AW-1:0];
    assign pop_data = mem[rd_idx];

    // storage write on push
    always_ff @(posedge clk) begin
        if (push) mem[head] <= push_data;
    end

    // head pointer and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else begin
            if (push) head <= head + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)));
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/serport_engine.sv
// Transfer engine and flag logic. It moves one word per cycle from the
// transmit queue to the receive queue while enabled, the transmit queue is
// non-empty and the receive queue is not full. Purely combinational.
module serport_engine
    import serport_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int RX_THR = 4,
    parameter int TX_THR = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          enable,
    input  logic          loopback,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [DW-1:0] tx_word,
    input  logic [DW-1:0] ext_word,
    input  logic [DW-1:0] frame_mask,
    output logic          move,
    output logic [DW-1:0] rx_word,
    output logic          ext_strobe,
    output stat_t         stat,
    output logic [1:0]    raw_irq
);
    logic tx_has, rx_room;

    // move decision
    always_comb begin
        tx_has  = (tx_count != '0);
        rx_room = (rx_count != CW'(DEPTH));
        move    = enable && tx_has && rx_room;
    end

    // received word source
    always_comb begin
        rx_word    = loopback ? tx_word : (ext_word & frame_mask);
        ext_strobe = move && !loopback;
    end

    // status flags
    always_comb begin
        stat.tx_empty  = !tx_has;
        stat.tx_nfull  = (tx_count != CW'(DEPTH));
        stat.rx_nempty = (rx_count != '0);
        stat.rx_full   = !rx_room;
        stat.busy      = enable && tx_has;
    end

    // raw interrupt thresholds
    always_comb begin
        raw_irq[0] = (rx_count >= CW'(RX_THR));
        raw_irq[1] = (tx_count <= CW'(TX_THR));
    end
endmodule

// File: rtl/serport_regs.sv
// Register front end of a synchronous serial port master. It decodes
// word-aligned accesses, masks transmit data to the programmed frame size,
// and joins two queues through the transfer engine. Read data is
// combinational in the access cycle, and a data read pops at the clock edge.
module serport_regs
    import serport_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int RX_THR = 4,
    parameter int TX_THR = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [11:0]   bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic [DW-1:0] link_tx_word,
    output logic          link_strobe,
    input  logic [DW-1:0] link_rx_word
);
    logic [DW-1:0] ctl0;
    logic [3:0]    ctl1;
    logic [7:0]    presc;
    logic [1:0]    imask;
    logic [DW-1:0] frame_mask;
    logic          wr_hit, rd_hit;
    logic          tx_push, rx_pop, move;
    logic [DW-1:0] tx_head_word, rx_head_word, rx_in_word;
    logic [CW-1:0] tx_count, rx_count;
    stat_t         stat;
    logic [1:0]    raw_irq;
    logic [7:0]    id_byte;

    // aligned access qualifiers
    assign wr_hit = bus_sel &&  bus_wr && (bus_addr[1:0] == 2'b00);
    assign rd_hit = bus_sel && !bus_wr && (bus_addr[1:0] == 2'b00);

    // frame mask: bits 0..N set
    always_comb begin
        for (int i = 0; i < DW; i++)
            frame_mask[i] = (i <= int'(ctl0[3:0]));
    end

    // queue push/pop qualification
    assign tx_push = wr_hit && (bus_addr == OFS_DATA) && (tx_count != CW'(DEPTH));
    assign rx_pop  = rd_hit && (bus_addr == OFS_DATA) && (rx_count != '0);

    // control, prescale and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0  <= '0;
            ctl1  <= '0;
            presc <= '0;
            imask <= '0;
        end else if (wr_hit) begin
            case (bus_addr)
                OFS_CTL0:  ctl0  <= bus_wdata;
                OFS_CTL1:  ctl1  <= bus_wdata[3:0];
                OFS_PRESC: presc <= bus_wdata[7:0];
                OFS_IMASK: imask <= bus_wdata[1:0];
                default:   ;
            endcase
        end
    end

    serport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(bus_wdata & frame_mask),
        .pop(move), .pop_data(tx_head_word), .count(tx_count)
    );

    serport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(move), .push_data(rx_in_word),
        .pop(rx_pop), .pop_data(rx_head_word), .count(rx_count)
    );

    serport_engine #(.DW(DW), .DEPTH(DEPTH), .RX_THR(RX_THR), .TX_THR(TX_THR)) u_eng (
        .enable(ctl1[C1_ENABLE]), .loopback(ctl1[C1_LOOP]),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_word(tx_head_word), .ext_word(link_rx_word), .frame_mask(frame_mask),
        .move(move), .rx_word(rx_in_word), .ext_strobe(link_strobe),
        .stat(stat), .raw_irq(raw_irq)
    );

    assign link_tx_word = tx_head_word;
    assign irq          = |(imask & raw_irq);

    // identification byte for the window slot
    assign id_byte = 8'(ID_BASE + ID_STEP * {5'b0, bus_addr[4:2]});

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            if (bus_addr[11:5] == ID_PAGE) begin
                bus_rdata = DW'(id_byte);
            end else begin
                case (bus_addr)
                    OFS_CTL0:  bus_rdata = ctl0;
                    OFS_CTL1:  bus_rdata = DW'(ctl1);
                    OFS_DATA:  bus_rdata = (rx_count != '0) ? rx_head_word : '0;
                    OFS_STAT:  bus_rdata = DW'(stat);
                    OFS_PRESC: bus_rdata = DW'(presc);
                    OFS_IMASK: bus_rdata = DW'(imask);
                    OFS_RAW:   bus_rdata = DW'(raw_irq);
                    OFS_MIS:   bus_rdata = DW'(imask & raw_irq);
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    // R5
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && bus_addr == OFS_DATA && rx_count == '0) |-> (bus_rdata == '0));
    // R6
    presc_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_addr == OFS_PRESC) |=> (presc == $past(bus_wdata[7:0])));
    // R10
    move_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count > $past(rx_count)) |-> $past(ctl1[C1_ENABLE]));
    // R3
    one_move_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= $past(rx_count) + 1'b1));
endmodule

// File: tb/tb_serport_regs.sv
`timescale 1ns/1ps
module tb_serport_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic        irq;
    logic [15:0] link_tx_word, link_rx_word = '0;
    logic        link_strobe;

    int vectors = 0, errors = 0, link_seen = 0;
    bit done = 0;
    string cur_req = "R3";
    logic [15:0] sb_q[$];
    logic [15:0] link_exp = '0;

    always #10 clk = ~clk;   // 50 MHz

    serport_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
        .link_tx_word(link_tx_word), .link_strobe(link_strobe),
        .link_rx_word(link_rx_word)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [15:0] d);
        @(posedge clk); #2;
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [15:0] d);
        @(posedge clk); #2;
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        @(posedge clk); #2;
        sel = 1'b0;
    endtask

    task automatic read_check(string req, logic [11:0] a, logic [15:0] exp);
        logic [15:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    // driver: write a word, record the expected received value
    task automatic push_word(logic [15:0] d, bit accept, logic [15:0] exp);
        bus_write(12'h008, d);
        if (accept) sb_q.push_back(exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic irq_check(string req, logic exp);
        @(negedge clk);
        check(req, {15'b0, irq}, {15'b0, exp});
    endtask

    // monitor: every data-register read is compared with the scoreboard
    always @(negedge clk) begin
        if (rst_n && sel && !wr && addr == 12'h008) begin
            logic [15:0] e;
            e = (sb_q.size() > 0) ? sb_q.pop_front() : 16'h0000;
            check(cur_req, rdata, e);
        end
    end

    // monitor: external link transfers
    always @(negedge clk) begin
        if (rst_n && link_strobe) begin
            link_seen++;
            check("R12", link_tx_word, link_exp);
        end
    end

    // watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        idle(4); #2 rst_n = 1'b1;

        // R1 reset state
        read_check("R1", 12'h00C, 16'h0003);
        read_check("R1", 12'h018, 16'h0002);
        read_check("R1", 12'h01C, 16'h0000);
        irq_check("R1", 1'b0);

        // R10 control storage widths
        bus_write(12'h000, 16'hBCD7);
        read_check("R10", 12'h000, 16'hBCD7);
        bus_write(12'h004, 16'hFFF4);
        read_check("R10", 12'h004, 16'h0004);

        // R6 prescale
        bus_write(12'h010, 16'h1234);
        read_check("R6", 12'h010, 16'h0034);

        // R9 DMA and undefined offsets
        bus_write(12'h020, 16'hFFFF);
        read_check("R9", 12'h020, 16'h0000);
        bus_write(12'h024, 16'h5555);
        read_check("R9", 12'h024, 16'h0000);
        read_check("R9", 12'h000, 16'hBCD7);
        read_check("R9", 12'h004, 16'h0004);

        // R8 identification window
        for (int k = 0; k < 8; k++)
            read_check("R8", 12'hFE0 + 12'(4 * k), 16'(8'h50 + 8'h11 * k));

        // R2, R3 loopback with several frame sizes
        cur_req = "R2";
        bus_write(12'h000, 16'h0007);
        bus_write(12'h004, 16'h0003);
        push_word(16'h1234, 1, 16'h0034);
        push_word(16'hFF5A, 1, 16'h005A);
        bus_write(12'h000, 16'h000F);
        push_word(16'hBEEF, 1, 16'hBEEF);
        bus_write(12'h000, 16'h0003);
        push_word(16'h00F9, 1, 16'h0009);
        idle(4);
        cur_req = "R3";
        for (int i = 0; i < 4; i++) begin logic [15:0] v; bus_read(12'h008, v); end
        cur_req = "R5";
        begin logic [15:0] v; bus_read(12'h008, v); end
        read_check("R5", 12'h00C, 16'h0003);

        // R10, R11 engine disabled, then rx threshold
        cur_req = "R10";
        bus_write(12'h000, 16'h000F);
        bus_write(12'h004, 16'h0001);
        for (int i = 0; i < 4; i++) push_word(16'hA000 + 16'(i), 1, 16'hA000 + 16'(i));
        idle(3);
        read_check("R10", 12'h00C, 16'h0002);
        bus_write(12'h004, 16'h0003);
        idle(6);
        read_check("R10", 12'h00C, 16'h0007);
        read_check("R11", 12'h018, 16'h0003);
        cur_req = "R3";
        begin logic [15:0] v; bus_read(12'h008, v); end
        read_check("R11", 12'h018, 16'h0002);
        for (int i = 0; i < 3; i++) begin logic [15:0] v; bus_read(12'h008, v); end

        // R4, R11 fill the transmit queue while disabled
        bus_write(12'h004, 16'h0001);
        for (int i = 0; i < 4; i++) push_word(16'h1000 + 16'(i), 1, 16'h1000 + 16'(i));
        read_check("R11", 12'h018, 16'h0002);
        push_word(16'h1004, 1, 16'h1004);
        read_check("R11", 12'h018, 16'h0000);
        for (int i = 5; i < 8; i++) push_word(16'h1000 + 16'(i), 1, 16'h1000 + 16'(i));
        push_word(16'hDEAD, 0, 16'h0000);
        read_check("R4", 12'h00C, 16'h0000);
        bus_write(12'h004, 16'h0003);
        idle(12);
        read_check("R4", 12'h00C, 16'h000F);
        read_check("R11", 12'h018, 16'h0003);
        push_word(16'h2000, 1, 16'h2000);
        push_word(16'h2001, 1, 16'h2001);
        read_check("R1", 12'h00C, 16'h001E);

        // R7 masked status and interrupt
        bus_write(12'h014, 16'h0001);
        read_check("R7", 12'h01C, 16'h0001);
        irq_check("R7", 1'b1);
        bus_write(12'h014, 16'h0002);
        read_check("R7", 12'h01C, 16'h0002);
        irq_check("R7", 1'b1);
        bus_write(12'h014, 16'h0000);
        irq_check("R7", 1'b0);

        cur_req = "R4";
        for (int i = 0; i < 10; i++) begin logic [15:0] v; bus_read(12'h008, v); end
        cur_req = "R5";
        begin logic [15:0] v; bus_read(12'h008, v); end

        // R12 external link
        cur_req = "R12";
        link_rx_word = 16'h3CA5;
        link_exp = 16'h00F0;
        bus_write(12'h000, 16'h0007);
        bus_write(12'h004, 16'h0002);
        push_word(16'h01F0, 1, 16'h00A5);
        idle(4);
        begin logic [15:0] v; bus_read(12'h008, v); end
        check("R12", 16'(link_seen), 16'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule